// File: doc/BRIEF.md
# Single-Chain Successive Approximation Controller

This block is the digital search engine of an 8-bit successive approximation converter. It drives a trial code to an external DAC and reads back one comparator decision per clock. From these it builds the result by binary search, starting from the most significant bit. The result uses one register per bit. Each bit register holds the trial '1' while its bit is tested, then keeps the decided value. No second chain of registers sequences the search.

Each bit cell has three modes, picked by a small per-bit decoder. In shift mode the cell takes the trial marker from the stage above it. In load mode it captures the comparator decision. In hold mode it keeps its value. A one-hot pointer outside the result word marks the bit under test. Each cell has an enable that is high only on the clock edges where the cell can change. This enable stands in for clock gating.

A start request from idle sets the word to midscale. Eight decisions follow. A one-cycle done pulse then marks the end, and the final code stays on the word output until the next start.

Top module: `sar_nr_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the word to 0, clears the pointer, and drives `busy` and `done` to 0.
- R2: A `start` sampled high while `busy` is 0 gives `word` = 8'h80 and `busy` = 1 after that edge.
- R3: On each rising edge while `busy` is 1, the bit under test keeps its value of 1 if `cmp_hi` is 1 (input above the DAC level). Otherwise the bit is cleared to 0. Against an ideal comparator, the final code therefore equals the input level.
- R4: On the same edge as each decision except the last, the next lower bit becomes 1 and every bit below it stays 0.
- R5: A decided bit keeps its value for the rest of the conversion.
- R6: Exactly 8 decision edges follow an accepted start. After the 8th, `done` is 1 for exactly one cycle, and `busy` is 0 in that same cycle.
- R7: While idle with no start, `word` holds the last result unchanged, whatever `cmp_hi` does.
- R8: A `start` sampled while `busy` is 1 is ignored. The running conversion continues and ends at its original time with its original result.
- R9: During a conversion, at most two bit cells are enabled per cycle: the cell under test and the cell receiving the trial marker. Every disabled cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, taken only while idle |
| cmp_hi | input | 1 | Comparator decision: 1 when the held input is above the DAC level |
| word | output | 8 | Trial code during a conversion; result code afterwards (bit 7 = MSB) |
| busy | output | 1 | High from the edge after start until the last decision edge |
| done | output | 1 | One-cycle pulse after the last decision |

## Verification
The assertions assume that `cmp_hi` carries a valid decision on every edge while `busy` is high. They also assume that `rst` is held for at least one edge before the first start. They make no assumption about `start` timing, so a start during a conversion is legal input. The stimulus drives `cmp_hi` from an ideal comparator: it compares a bench input level with the live `word` output. Inputs change only on falling edges. Stimulus covers the extreme codes, midscale neighbours, alternating patterns, a start issued mid-conversion and a reset issued mid-conversion.

// File: rtl/sar_nr_pkg.sv
package sar_nr_pkg;

    typedef enum logic [1:0] {
        BM_HOLD  = 2'd0,
        BM_SHIFT = 2'd1,
        BM_LOAD  = 2'd2
    } bit_mode_e;

endpackage

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             go,
    output logic [WIDTH-1:0] ptr,
    output logic             busy,
    output logic             done
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] ptr;
        logic             busy;
        logic             done;
    } step_state_t;

    step_state_t st_d, st_q;

    assign go = start & ~st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.ptr = st_q.ptr >> 1;
            if (st_q.ptr[0]) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (go) begin
            st_d.ptr  = TOP_ONE;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign busy = st_q.busy;
    assign done = st_q.done;
endmodule

// File: rtl/sar_mode_dec.sv
module sar_mode_dec
    import sar_nr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 go,
    input  logic [WIDTH-1:0]     ptr,
    output bit_mode_e            mode [WIDTH],
    output logic [WIDTH-1:0]     en,
    output logic [WIDTH-1:0]     shift_in
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_dec
        logic above;
        if (i == WIDTH - 1) begin : g_top
            assign above = go;
        end else begin : g_low
            assign above = ptr[i+1];
        end

        always_comb begin
            if (go) begin
                mode[i] = BM_SHIFT;
            end else if (ptr[i]) begin
                mode[i] = BM_LOAD;
            end else if (above) begin
                mode[i] = BM_SHIFT;
            end else begin
                mode[i] = BM_HOLD;
            end
        end

        assign en[i]       = go | ptr[i] | above;
        assign shift_in[i] = above;
    end
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
    import sar_nr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  bit_mode_e mode,
    input  logic      shift_in,
    input  logic      cmp_hi,
    output logic      q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) begin
            case (mode)
                BM_SHIFT: q_d = shift_in;
                BM_LOAD:  q_d = cmp_hi;
                default:  q_d = q_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;
endmodule

// File: rtl/sar_nr_ctrl.sv
module sar_nr_ctrl
    import sar_nr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] word,
    output logic             busy,
    output logic             done
);
    localparam int MSB = WIDTH - 1;

    logic             go;
    logic [WIDTH-1:0] ptr_q;
    logic [WIDTH-1:0] bit_en;
    logic [WIDTH-1:0] bit_shift_in;
    bit_mode_e        bit_mode [WIDTH];
    logic [MSB:0]     cell_q;

    sar_step_ctrl #(.WIDTH(WIDTH)) u_step (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .go    (go),
        .ptr   (ptr_q),
        .busy  (busy),
        .done  (done)
    );

    sar_mode_dec #(.WIDTH(WIDTH)) u_dec (
        .go       (go),
        .ptr      (ptr_q),
        .mode     (bit_mode),
        .en       (bit_en),
        .shift_in (bit_shift_in)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        sar_bit_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .en       (bit_en[i]),
            .mode     (bit_mode[i]),
            .shift_in (bit_shift_in[i]),
            .cmp_hi   (cmp_hi),
            .q        (cell_q[i])
        );
    end

    assign word = cell_q;
endmodule

// File: rtl/sar_nr_ctrl_chk.sv
module sar_nr_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             cmp_hi,
    input logic [WIDTH-1:0] word,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] ptr,
    input logic [WIDTH-1:0] en
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

    logic [CNT_W-1:0] n_dec_q;
    logic [WIDTH-1:0] above_mask;

    assign above_mask = ~((ptr << 1) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_dec_q <= '0;
        end else if (start && !busy) begin
            n_dec_q <= '0;
        end else if (busy) begin
            n_dec_q <= n_dec_q + 1'b1;
        end
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (word == '0 && !busy && !done && ptr == '0));

    // R2
    p_start_mid_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (word == MID && busy));

    // R3
    p_decide_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> (((word & $past(ptr)) != '0) == $past(cmp_hi)));

    // R4
    p_next_trial_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !ptr[0]) |=> ((word & ($past(ptr) >> 1)) != '0));

    // R5
    p_decided_kept_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((word & $past(above_mask)) == ($past(word) & $past(above_mask))));

    // R6
    p_done_count_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && n_dec_q == CNT_W'(WIDTH)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(word));

    // R8
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !ptr[0]) |=> busy);

    // R9
    p_two_enables_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(en) <= 2 && $onehot0(ptr)));

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        p_gated_keep_r9: assert property (@(posedge clk) disable iff (rst)
            !en[i] |=> $stable(word[i]));
    end
endmodule

bind sar_nr_ctrl sar_nr_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cmp_hi (cmp_hi),
    .word   (word),
    .busy   (busy),
    .done   (done),
    .ptr    (ptr_q),
    .en     (bit_en)
);

// File: tb/sar_nr_ctrl_test.sv
module sar_nr_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] vin = 8'd0;
    logic       cmp_hi;
    logic [7:0] word;
    logic       busy;
    logic       done;

    int n_chk = 0;
    int n_fail = 0;
    bit trace_on = 1'b0;

    int m_word = 0;
    int m_pos = -1;
    bit m_busy = 1'b0;
    bit m_done = 1'b0;

    always #5 clk = ~clk;

    assign cmp_hi = (vin >= word);

    sar_nr_ctrl uut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_hi (cmp_hi),
        .word   (word),
        .busy   (busy),
        .done   (done)
    );

    // behavioural reference: integer code plus a bit index
    always @(posedge clk) begin
        if (rst) begin
            m_word = 0; m_pos = -1; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (!(int'(vin) >= m_word)) m_word = m_word - (1 << m_pos);
                if (m_pos == 0) begin
                    m_busy = 0; m_done = 1; m_pos = -1;
                end else begin
                    m_pos = m_pos - 1;
                    m_word = m_word + (1 << m_pos);
                end
            end else if (start) begin
                m_word = 128; m_busy = 1; m_pos = 7;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (trace_on) begin
            check("R5 word vs model", int'(word), m_word);
            check("R6 busy vs model", int'(busy), int'(m_busy));
            check("R6 done vs model", int'(done), int'(m_done));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_conv(logic [7:0] v);
        vin = v;
        start = 1'b1;
        cycles(1);
        start = 1'b0;
        check("R2 word at start", int'(word), 8'h80);
        check("R2 busy at start", int'(busy), 1);
        cycles(1);
        check("R4 first trial", int'(word), int'((v & 8'h80) | 8'h40));
        cycles(7);
        check("R6 done pulse", int'(done), 1);
        check("R6 busy low", int'(busy), 0);
        check("R3 final code", int'(word), int'(v));
        cycles(1);
        check("R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("[TB] FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        cycles(3);
        check("R1 reset word", int'(word), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        rst = 1'b0;
        trace_on = 1'b1;
        cycles(2);

        foreach (pat[k]) run_conv(pat[k]);

        // R7: idle with comparator toggling
        vin = 8'hAA;
        run_conv(8'hAA);
        vin = 8'h00;
        cycles(4);
        check("R7 idle hold", int'(word), 8'hAA);

        // R9: bits below the trial stay zero
        vin = 8'hFF;
        start = 1'b1;
        cycles(1);
        start = 1'b0;
        cycles(3);
        check("R9 lower bits untouched", int'(word & 8'h0F), 0);
        check("R4 trial bit set", int'(word), 8'hF0);
        cycles(6);

        // R8: start during a conversion
        vin = 8'h3C;
        start = 1'b1;
        cycles(1);
        start = 1'b0;
        cycles(2);
        start = 1'b1;
        cycles(1);
        start = 1'b0;
        check("R8 still busy", int'(busy), 1);
        cycles(5);
        check("R8 done on time", int'(done), 1);
        check("R8 result kept", int'(word), 8'h3C);
        cycles(2);

        // R1: reset during a conversion
        vin = 8'h99;
        start = 1'b1;
        cycles(1);
        start = 1'b0;
        cycles(3);
        rst = 1'b1;
        cycles(1);
        check("R1 mid reset word", int'(word), 0);
        check("R1 mid reset busy", int'(busy), 0);
        rst = 1'b0;
        cycles(2);
        run_conv(8'h5A);

        trace_on = 1'b0;
        finish_run();
    end

    logic [7:0] pat [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h55, 8'h01};
endmodule